// File: doc/BRIEF.md
# Sixty-four source interrupt controller

This block collects 64 level-sensitive interrupt inputs and drives two request lines towards a processor: a fast request and a normal request. Each source has a pending bit, an enable bit and a type bit. The type bit steers an enabled, pending source to the fast line when set and to the normal line when clear. Normal sources also carry a 4-bit priority. A 5-bit mask acts as a threshold for the normal line.

Software reaches all state through a word-addressed register port. Writes complete in one cycle. Read data is registered and appears on the cycle after the read strobe. Enables can be changed one source at a time, by writing a source number to a set register or a clear register, or 32 bits at a time through the high and low words. A force register writes the pending vector directly.

Two vector registers report the winning source and clear its pending bit as a side effect of the read. The normal vector returns the highest priority, and on a tie the highest source number. The fast vector returns the lowest source number. A separate priority tree finds the normal winner, and a separate find-first block finds the fast winner.

Top module: `intc64_top`

## Requirements
- R1: After reset, the pending, enable, type, control and priority state are all zero and the mask reads 0x1f. irq_o and fiq_o are low, and both vector reads return 0xFFFFFFFF.
- R2: When a source input changes level, its pending bit takes the new level at the next clock edge. A pending bit is set even when its source is disabled. Only pending AND enabled sources can request.
- R3: fiq_o is high exactly when some source is pending, enabled and has its type bit at 1.
- R4: Normal requests are sources that are pending, enabled and have type bit 0. When the mask (word 1, low 5 bits) is 0x1f, irq_o is high if any normal request exists. For any other mask value, irq_o is high only if some normal request has a priority numerically greater than the mask.
- R5: A write to word 2 sets the enable bit of the source numbered by bits [5:0] of the data. A write to word 3 clears it. All higher data bits are ignored, and words 2 and 3 read as zero.
- R6: Enable is at words 4 (sources 63..32) and 5 (sources 31..0). Type is at words 6 (high) and 7 (low). A write to one half leaves the other half unchanged, and both halves read back what was written.
- R7: Words 20 (high) and 21 (low) overwrite that half of the pending vector and read as zero. Pending reads back at words 18 (high) and 19 (low).
- R8: Words 22/23 (high/low) read pending AND enabled AND NOT type. Words 24/25 (high/low) read pending AND enabled AND type.
- R9: Priority words 8..15 hold eight 4-bit fields each. Word 15 holds sources 0..7, word 14 holds sources 8..15, and so on down to word 8, which holds sources 56..63. Source n uses bits [4*(n%8)+3 : 4*(n%8)].
- R10: A read of word 16 picks, among normal requests, the highest priority, and on a tie the highest source number. It returns (n<<16)|priority and clears that pending bit. With no normal request it returns 0xFFFFFFFF.
- R11: A read of word 17 returns the lowest-numbered fast request (pending, enabled, type 1) and clears its pending bit. With none it returns 0xFFFFFFFF. Each read strobe cycle clears at most one pending bit.
- R12: Writes to words 16..19 and 22..25 are ignored. Word 0x40 reads as 4. Any other unmapped word reads as zero and ignores writes.
- R13: The control word (0) stores the write data AND CTRL_WMASK (default 0x3F), and the mask stores data bits [4:0]. rdata_o shows the addressed value one cycle after rd_i and is zero in a cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level-sensitive interrupt sources |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe, one read per high cycle |
| addr_i | input | 8 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Arbitration is exercised with several patterns, each aimed at one part of the selection logic:
- Two normal sources with different priorities are read out in turn; this separates priority order from source-number order.
- Three sources at equal priority, one of them in the top word, show that ties go to the highest source number and that the reversed priority-word order is decoded correctly.
- A sweep of the mask across 0x1f, values just above and below the winning priority, a value above every 4-bit priority, and zero separates the all-pass case from the strict greater-than threshold.
- Mixed fast and normal sources check the type steering. They confirm that the normal vector ignores fast sources, and that the fast vector drains in ascending order across both halves.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned N_SRC   = 64;
  localparam int unsigned HALF_W  = 32;
  localparam int unsigned PRIO_W  = 4;
  localparam int unsigned MASK_W  = 5;
  localparam int unsigned ID_W    = $clog2(N_SRC);
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned PER_WRD = HALF_W / PRIO_W;
  localparam int unsigned P_WORDS = N_SRC / PER_WRD;

  localparam logic [ADDR_W-1:0] A_CTRL    = 8'd0;
  localparam logic [ADDR_W-1:0] A_MASK    = 8'd1;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 8'd2;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 8'd3;
  localparam logic [ADDR_W-1:0] A_EN_HI   = 8'd4;
  localparam logic [ADDR_W-1:0] A_EN_LO   = 8'd5;
  localparam logic [ADDR_W-1:0] A_TY_HI   = 8'd6;
  localparam logic [ADDR_W-1:0] A_TY_LO   = 8'd7;
  localparam logic [ADDR_W-1:0] A_NVEC    = 8'd16;
  localparam logic [ADDR_W-1:0] A_FVEC    = 8'd17;
  localparam logic [ADDR_W-1:0] A_PND_HI  = 8'd18;
  localparam logic [ADDR_W-1:0] A_PND_LO  = 8'd19;
  localparam logic [ADDR_W-1:0] A_FRC_HI  = 8'd20;
  localparam logic [ADDR_W-1:0] A_FRC_LO  = 8'd21;
  localparam logic [ADDR_W-1:0] A_NP_HI   = 8'd22;
  localparam logic [ADDR_W-1:0] A_NP_LO   = 8'd23;
  localparam logic [ADDR_W-1:0] A_FP_HI   = 8'd24;
  localparam logic [ADDR_W-1:0] A_FP_LO   = 8'd25;
  localparam logic [ADDR_W-1:0] A_CONST   = 8'h40;

  localparam logic [HALF_W-1:0] NONE_VAL  = '1;
  localparam logic [HALF_W-1:0] CONST_VAL = 32'd4;
endpackage

// File: rtl/intc_prio_tree.sv
// Max-priority tournament; ties resolve toward the higher source index.
module intc_prio_tree #(
  parameter int unsigned N  = 64,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned NODES = 2 * N - 1
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW-1:0]   prio_o
);
  logic          nv [NODES];
  logic [PW-1:0] np [NODES];
  logic [IW-1:0] ni [NODES];

  for (genvar gi = 0; gi < N; gi++) begin : g_leaf
    assign nv[N-1+gi] = req_i[gi];
    assign np[N-1+gi] = prio_i[gi*PW +: PW];
    assign ni[N-1+gi] = IW'(gi);
  end

  for (genvar gk = 0; gk < N - 1; gk++) begin : g_node
    logic take_r;
    assign take_r = nv[2*gk+2] && (!nv[2*gk+1] || (np[2*gk+2] >= np[2*gk+1]));
    assign nv[gk] = nv[2*gk+1] || nv[2*gk+2];
    assign np[gk] = take_r ? np[2*gk+2] : np[2*gk+1];
    assign ni[gk] = take_r ? ni[2*gk+2] : ni[2*gk+1];
  end

  assign valid_o = nv[0];
  assign idx_o   = ni[0];
  assign prio_o  = np[0];

  always_comb begin
    if (!$isunknown(req_i) && !$isunknown(prio_i)) begin
      a_r10_valid_any: assert (valid_o == (|req_i));
      if (valid_o) begin
        a_r10_win_is_req: assert (req_i[idx_o]);
        for (int i = 0; i < N; i++) begin
          if (req_i[i]) begin
            a_r10_win_max: assert ((prio_i[i*PW +: PW] < prio_o) ||
                                   ((prio_i[i*PW +: PW] == prio_o) && (IW'(i) <= idx_o)));
          end
        end
      end
    end
  end
endmodule

// File: rtl/intc_low_pick.sv
// Lowest-index set bit.
module intc_low_pick #(
  parameter int unsigned N = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign valid_o = |req_i;

  always_comb begin
    if (!$isunknown(req_i) && valid_o) begin
      a_r11_pick_set: assert (req_i[idx_o]);
      for (int i = 0; i < N; i++) begin
        if (IW'(i) < idx_o) a_r11_pick_lowest: assert (!req_i[i]);
      end
    end
  end
endmodule

// File: rtl/intc64_top.sv
module intc64_top
  import intc_pkg::*;
#(
  parameter logic [HALF_W-1:0] CTRL_WMASK = 32'h0000_003F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [MASK_W-1:0] MASK_OPEN = '1;

  logic [N_SRC-1:0]  pend_q, pend_d, en_q, en_d, ty_q, ty_d;
  logic [N_SRC-1:0]  src_q, chg;
  logic [HALF_W-1:0] ctrl_q;
  logic [MASK_W-1:0] mask_q;
  logic [P_WORDS-1:0][HALF_W-1:0] prio_q;
  logic [HALF_W-1:0] rd_val, rdata_q;

  logic [N_SRC-1:0]  eff, nreq, freq;
  logic              n_valid, f_valid;
  logic [ID_W-1:0]   n_idx, f_idx;
  logic [PRIO_W-1:0] n_prio;

  logic is_prio_addr;
  logic [$clog2(P_WORDS)-1:0] prio_sel;

  assign eff  = pend_q & en_q;
  assign nreq = eff & ~ty_q;
  assign freq = eff & ty_q;
  assign chg  = src_i ^ src_q;

  assign is_prio_addr = (addr_i >= 8'd8) && (addr_i <= 8'd15);
  assign prio_sel     = ~addr_i[2:0]; // word 15 -> sources 0..7

  intc_prio_tree #(.N(N_SRC), .PW(PRIO_W)) u_tree (
    .req_i   (nreq),
    .prio_i  (prio_q),
    .valid_o (n_valid),
    .idx_o   (n_idx),
    .prio_o  (n_prio)
  );

  intc_low_pick #(.N(N_SRC)) u_fast (
    .req_i   (freq),
    .valid_o (f_valid),
    .idx_o   (f_idx)
  );

  // winner priority is the maximum, so it alone decides the threshold
  assign irq_o = n_valid && ((mask_q == MASK_OPEN) || ({1'b0, n_prio} > mask_q));
  assign fiq_o = f_valid;

  always_comb begin
    pend_d = pend_q;
    if (wr_i && addr_i == A_FRC_HI) pend_d[N_SRC-1:HALF_W] = wdata_i;
    if (wr_i && addr_i == A_FRC_LO) pend_d[HALF_W-1:0]     = wdata_i;
    if (rd_i && addr_i == A_NVEC && n_valid) pend_d[n_idx] = 1'b0;
    if (rd_i && addr_i == A_FVEC && f_valid) pend_d[f_idx] = 1'b0;
    // a level change on the input wins over software for that bit
    pend_d = (pend_d & ~chg) | (src_i & chg);
  end

  always_comb begin
    en_d = en_q;
    ty_d = ty_q;
    if (wr_i) begin
      case (addr_i)
        A_EN_SET: en_d[wdata_i[ID_W-1:0]] = 1'b1;
        A_EN_CLR: en_d[wdata_i[ID_W-1:0]] = 1'b0;
        A_EN_HI:  en_d[N_SRC-1:HALF_W]    = wdata_i;
        A_EN_LO:  en_d[HALF_W-1:0]        = wdata_i;
        A_TY_HI:  ty_d[N_SRC-1:HALF_W]    = wdata_i;
        A_TY_LO:  ty_d[HALF_W-1:0]        = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      ty_q   <= '0;
      src_q  <= '0;
      ctrl_q <= '0;
      mask_q <= MASK_OPEN;
      prio_q <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      ty_q   <= ty_d;
      src_q  <= src_i;
      if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i & CTRL_WMASK;
      if (wr_i && addr_i == A_MASK) mask_q <= wdata_i[MASK_W-1:0];
      if (wr_i && is_prio_addr)     prio_q[prio_sel] <= wdata_i;
    end
  end

  always_comb begin
    rd_val = '0;
    if (is_prio_addr) begin
      rd_val = prio_q[prio_sel];
    end else begin
      case (addr_i)
        A_CTRL:   rd_val = ctrl_q;
        A_MASK:   rd_val = HALF_W'(mask_q);
        A_EN_HI:  rd_val = en_q[N_SRC-1:HALF_W];
        A_EN_LO:  rd_val = en_q[HALF_W-1:0];
        A_TY_HI:  rd_val = ty_q[N_SRC-1:HALF_W];
        A_TY_LO:  rd_val = ty_q[HALF_W-1:0];
        A_NVEC:   rd_val = n_valid ? ((HALF_W'(n_idx) << 16) | HALF_W'(n_prio)) : NONE_VAL;
        A_FVEC:   rd_val = f_valid ? HALF_W'(f_idx) : NONE_VAL;
        A_PND_HI: rd_val = pend_q[N_SRC-1:HALF_W];
        A_PND_LO: rd_val = pend_q[HALF_W-1:0];
        A_NP_HI:  rd_val = nreq[N_SRC-1:HALF_W];
        A_NP_LO:  rd_val = nreq[HALF_W-1:0];
        A_FP_HI:  rd_val = freq[N_SRC-1:HALF_W];
        A_FP_LO:  rd_val = freq[HALF_W-1:0];
        A_CONST:  rd_val = CONST_VAL;
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_i ? rd_val : '0;
  end
  assign rdata_o = rdata_q;

  logic frc_wr, ro_wr;
  assign frc_wr = wr_i && (addr_i == A_FRC_HI || addr_i == A_FRC_LO);
  assign ro_wr  = wr_i && ((addr_i >= A_NVEC && addr_i <= A_PND_LO) ||
                           (addr_i >= A_NP_HI && addr_i <= A_FP_LO));

  a_r5_num_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (addr_i == A_EN_SET || addr_i == A_EN_CLR) |=> rdata_o == '0);

  a_r11_fvec_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == A_FVEC && f_valid && !chg[f_idx] && !frc_wr
    |=> !pend_q[$past(f_idx)]);

  a_r10_nvec_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == A_NVEC && n_valid && !chg[n_idx] && !frc_wr
    |=> !pend_q[$past(n_idx)]);

  a_r11_one_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (chg == '0) && !frc_wr
    |=> $countones($past(pend_q) & ~pend_q) <= 1);

  a_r12_ro_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_wr && !rd_i && (chg == '0) |=> pend_q == $past(pend_q));

  a_r2_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg != '0 |=> ((pend_q ^ $past(src_i)) & $past(chg)) == '0);
endmodule

// File: tb/sim_intc64_top.sv
module sim_intc64_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  intc64_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); d = rdata; rd = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rreg(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fiq", {31'b0, fiq}, 0);
    rchk("R1 ctrl", 8'd0, 0);
    rchk("R1 mask", 8'd1, 32'h1f);
    rchk("R1 en_lo", 8'd5, 0);
    rchk("R1 prio", 8'd15, 0);
    rchk("R1 nvec", 8'd16, 32'hFFFF_FFFF);
    rchk("R1 fvec", 8'd17, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable_num;
    wreg(8'd2, 32'h0000_0045);
    rchk("R5 set low6", 8'd5, 32'h20);
    wreg(8'd2, 32'd40);
    rchk("R5 set hi", 8'd4, 32'h100);
    rchk("R5 setreg zero", 8'd2, 0);
    rchk("R5 clrreg zero", 8'd3, 0);
    wreg(8'd3, 32'hFFFF_FF05);
    rchk("R5 clr", 8'd5, 0);
    wreg(8'd3, 32'd40);
    rchk("R5 clr hi", 8'd4, 0);
  endtask

  task automatic t_halves;
    wreg(8'd5, 32'hA5A5_A5A5);
    wreg(8'd4, 32'h1234_5678);
    rchk("R6 en lo", 8'd5, 32'hA5A5_A5A5);
    wreg(8'd5, 32'h0);
    rchk("R6 en hi kept", 8'd4, 32'h1234_5678);
    wreg(8'd6, 32'hDEAD_BEEF);
    wreg(8'd7, 32'h0F0F_0F0F);
    wreg(8'd6, 32'hDEAD_BEEF);
    rchk("R6 ty lo kept", 8'd7, 32'h0F0F_0F0F);
    rchk("R6 ty hi", 8'd6, 32'hDEAD_BEEF);
    wreg(8'd4, 0); wreg(8'd6, 0); wreg(8'd7, 0);
  endtask

  task automatic t_source_fast;
    wreg(8'd5, 32'h8);
    @(negedge clk); src[3] = 1'b1; src[4] = 1'b1;
    @(negedge clk);
    chk("R4 irq open mask", {31'b0, irq}, 1);
    chk("R3 fiq normal only", {31'b0, fiq}, 0);
    rchk("R2 pending incl disabled", 8'd19, 32'h18);
    rchk("R8 normal pending", 8'd23, 32'h8);
    wreg(8'd7, 32'h8);
    chk("R3 fiq", {31'b0, fiq}, 1);
    chk("R4 irq gone", {31'b0, irq}, 0);
    rchk("R8 fast pending", 8'd25, 32'h8);
    rchk("R8 normal pending empty", 8'd23, 0);
    @(negedge clk); src = '0;
    @(negedge clk);
    chk("R2 fiq after drop", {31'b0, fiq}, 0);
    rchk("R2 pending cleared", 8'd19, 0);
    wreg(8'd7, 0); wreg(8'd5, 0);
  endtask

  task automatic t_force;
    wreg(8'd21, 32'h30);
    rchk("R7 force lo", 8'd19, 32'h30);
    chk("R2 not enabled", {31'b0, irq}, 0);
    wreg(8'd20, 32'h1);
    rchk("R7 force hi", 8'd18, 32'h1);
    rchk("R7 lo kept", 8'd19, 32'h30);
    rchk("R7 frc hi zero", 8'd20, 0);
    rchk("R7 frc lo zero", 8'd21, 0);
    wreg(8'd20, 0); wreg(8'd21, 0);
  endtask

  task automatic t_prio_mask;
    wreg(8'd15, 32'h300);
    wreg(8'd14, 32'h700);
    wreg(8'd5, 32'h404);
    wreg(8'd21, 32'h404);
    chk("R4 mask 1f", {31'b0, irq}, 1);
    wreg(8'd1, 32'd6);
    chk("R4 mask 6", {31'b0, irq}, 1);
    wreg(8'd1, 32'd7);
    chk("R4 mask 7", {31'b0, irq}, 0);
    wreg(8'd1, 32'h10);
    chk("R4 mask 10", {31'b0, irq}, 0);
    wreg(8'd1, 32'd0);
    chk("R4 mask 0", {31'b0, irq}, 1);
    wreg(8'd1, 32'h1f);
    rchk("R9 word15", 8'd15, 32'h300);
    rchk("R9 word14", 8'd14, 32'h700);
  endtask

  task automatic t_nvec;
    rchk("R10 first", 8'd16, 32'h000A_0007);
    rchk("R10 cleared one", 8'd19, 32'h4);
    rchk("R10 second", 8'd16, 32'h0002_0003);
    rchk("R10 none", 8'd16, 32'hFFFF_FFFF);
    wreg(8'd15, 32'h700);
    wreg(8'd8, 32'h7000_0000);
    wreg(8'd4, 32'h8000_0000);
    wreg(8'd21, 32'h404);
    wreg(8'd20, 32'h8000_0000);
    rchk("R10 R9 tie top", 8'd16, 32'h003F_0007);
    rchk("R10 tie mid", 8'd16, 32'h000A_0007);
    rchk("R10 tie low", 8'd16, 32'h0002_0007);
    wreg(8'd4, 0); wreg(8'd5, 0);
  endtask

  task automatic t_fvec;
    wreg(8'd7, 32'h20); wreg(8'd6, 32'h100);
    wreg(8'd5, 32'h20); wreg(8'd4, 32'h100);
    wreg(8'd21, 32'h20); wreg(8'd20, 32'h100);
    chk("R3 fiq two", {31'b0, fiq}, 1);
    rchk("R10 ignores fast", 8'd16, 32'hFFFF_FFFF);
    rchk("R8 fast hi", 8'd24, 32'h100);
    rchk("R11 first", 8'd17, 32'd5);
    rchk("R11 second", 8'd17, 32'd40);
    rchk("R11 none", 8'd17, 32'hFFFF_FFFF);
    chk("R11 fiq drained", {31'b0, fiq}, 0);
    wreg(8'd4, 0); wreg(8'd5, 0); wreg(8'd6, 0); wreg(8'd7, 0);
  endtask

  task automatic t_misc;
    wreg(8'd0, 32'hFFFF_FFFF);
    rchk("R13 ctrl masked", 8'd0, 32'h3F);
    wreg(8'd1, 32'hFF);
    rchk("R13 mask 5b", 8'd1, 32'h1f);
    wreg(8'd21, 32'h7);
    wreg(8'd19, 32'h0);
    wreg(8'd23, 32'h0);
    wreg(8'd17, 32'h0);
    wreg(8'h30, 32'hFFFF_FFFF);
    rchk("R12 ro ignored", 8'd19, 32'h7);
    rchk("R12 const", 8'h40, 32'd4);
    rchk("R12 unmapped", 8'h30, 0);
    rchk("R12 unmapped ctrl kept", 8'd0, 32'h3F);
    @(negedge clk);
    chk("R13 idle rdata", rdata, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_num();
    t_halves();
    t_source_fast();
    t_force();
    t_prio_mask();
    t_nvec();
    t_fvec();
    t_misc();
    finish_run();
  end
endmodule